// File: doc/BRIEF.md
# Clockless Four-Phase Read Link

This block joins a read requester and a small response table over a link that has no shared clock. The requester side and the responder side each run on a clock of their own. They coordinate only through two level-sensitive lines: a request strobe driven by the requester and an acknowledge strobe driven by the responder. Every edge on one strobe is caused by the last edge seen on the other, so the link runs a fully interlocked four-phase handshake. Each side sees the other's strobe only through a synchronizer, so the two clocks may have any frequency and phase.

A read starts when the local user presents an address. The requester places the address and a read qualifier on the link. It holds them for a settle interval and then raises the request strobe. The responder sees the strobe and waits a programmable number of its own cycles to model access time. It then drives the selected table word and raises the acknowledge strobe. The requester captures the word, reports it to the user with a one-cycle pulse and drops the request strobe. The responder then clears the data lines and drops the acknowledge strobe. The requester accepts no new read until it has seen the acknowledge strobe low.

Requester states: `M_IDLE`, `M_SETTLE`, `M_WAIT_ACK`, `M_DROP`. Its transitions are:
- idle to settle when a request is taken.
- settle to wait-ack when the settle count expires, which raises the request strobe.
- wait-ack to drop when the acknowledge is seen high, which captures the data and lowers the strobe.
- drop to idle when the acknowledge is seen low.

Responder states: `S_IDLE`, `S_LATENCY`, `S_ACK`. Its transitions are:
- idle to latency when a read strobe is seen, which loads the delay count.
- latency to ack when the count reaches zero, which drives the data and raises the acknowledge.
- ack to idle when the strobe is seen low, which releases the data and lowers the acknowledge.

Top module: `async_rd_link`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, `rsp_valid` is 0, and `link_msync` and `link_ssync` are 0.
- R2: A read is taken on a `clk_m` edge where `req_valid` and `req_ready` are both 1. `link_msync` rises exactly SETTLE_CYC (default 3) `clk_m` cycles after that edge. The link address stays unchanged from acceptance until the requester is idle again.
- R3: `link_ssync` rises L+4 responder cycles after `link_msync` rises, where L is `lat_cycles`. Of these cycles, two are for synchronizing, one is for detection and L+1 are for the delay count.
- R4: `rsp_valid` pulses high for exactly one cycle, 3 cycles after `link_ssync` rises. `link_msync` falls on that same edge.
- R5: `rsp_data` at the pulse equals table word k for the accepted address k. Word k is ((k*0x1357) XOR 0xA5C3), truncated to DATA_W bits.
- R6: `link_ssync` falls 3 responder cycles after `link_msync` falls. The responder drives zero on the data lines whenever `link_ssync` is low.
- R7: `req_ready` returns to 1 three cycles after `link_ssync` falls. A whole read therefore occupies SETTLE_CYC+L+13 cycles. No new read starts before the acknowledge is seen low.
- R8: `req_valid` and `req_addr` are ignored while `req_ready` is 0. The response always carries the word for the address that was accepted.
- R9: `lat_cycles` may be any value from 0 to 2^LAT_W-1. It is sampled when the responder detects the request strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Requester clock |
| rst_m_n | input | 1 | Requester reset, active low, asynchronous |
| req_valid | input | 1 | Local read request |
| req_addr | input | ADDR_W | Table address to read |
| req_ready | output | 1 | Requester idle, able to take a read |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_data | output | DATA_W | Captured read word |
| clk_s | input | 1 | Responder clock |
| rst_s_n | input | 1 | Responder reset, active low, asynchronous |
| lat_cycles | input | LAT_W | Responder access delay, in responder cycles |
| link_msync | output | 1 | Request strobe as driven on the link |
| link_ssync | output | 1 | Acknowledge strobe as driven on the link |

## Verification
The bench clocks both sides from one clock so that every edge has a fixed offset from acceptance. Take acceptance as cycle 0. The request strobe is then due at cycle S and the acknowledge at S+L+4. The response pulse comes at S+L+7, the acknowledge drop at S+L+10 and the return of ready at S+L+13, where S is the settle count and L is the delay. A behavioural model counts cycles from acceptance and predicts all four outputs plus the response word. It is compared one time unit after every rising edge, when all registered outputs have settled and no input has yet moved. Requests presented while the requester is busy are fed to both the model and the design, so a design that takes them shows up as a mismatch in ready, strobe timing or data.

// File: rtl/async_rd_pkg.sv
package async_rd_pkg;

    typedef enum logic [1:0] {
        M_IDLE,
        M_SETTLE,
        M_WAIT_ACK,
        M_DROP
    } mst_state_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LATENCY,
        S_ACK
    } slv_state_e;

    // Contents of response table word idx
    function automatic logic [31:0] word_seed(input int idx);
        return (32'(idx) * 32'h0000_1357) ^ 32'h0000_A5C3;
    endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= {shreg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/rd_master.sv
module rd_master
    import async_rd_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 16,
    parameter int SETTLE_CYC  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_msync,
    input  logic              bus_ssync_in,
    input  logic [DATA_W-1:0] bus_data_in
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    mst_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              ssync_s;
    logic              settle_done;

    sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_ssync_in),
        .q     (ssync_s)
    );

    assign settle_done = (cnt_q == CNT_W'(SETTLE_CYC - 1));
    assign req_ready   = (state_q == M_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_IDLE:     if (req_valid)   state_d = M_SETTLE;
            M_SETTLE:   if (settle_done) state_d = M_WAIT_ACK;
            M_WAIT_ACK: if (ssync_s)     state_d = M_DROP;
            M_DROP:     if (!ssync_s)    state_d = M_IDLE;
            default:                     state_d = M_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_rd    <= 1'b0;
            bus_msync <= 1'b0;
            cnt_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                M_IDLE: begin
                    if (req_valid) begin
                        bus_addr <= req_addr;
                        bus_rd   <= 1'b1;
                        cnt_q    <= '0;
                    end
                end
                M_SETTLE: begin
                    if (settle_done) bus_msync <= 1'b1;
                    else             cnt_q     <= cnt_q + 1'b1;
                end
                M_WAIT_ACK: begin
                    if (ssync_s) begin
                        rsp_data  <= bus_data_in;
                        rsp_valid <= 1'b1;
                        bus_msync <= 1'b0;
                    end
                end
                M_DROP: begin
                    if (!ssync_s) bus_rd <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R2: address frozen while a read is in flight
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != M_IDLE) |=> (state_q == M_IDLE) || $stable(bus_addr));

    // R4: strobe only drops after the acknowledge was seen
    assert_msync_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_msync) |-> $past(ssync_s));

    // R4: response pulse never lasts two cycles
    assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7: idle only with acknowledge low
    assert_idle_ack_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == M_IDLE) |-> !ssync_s);

    // R2: strobe raised only with the read qualifier up
    assert_msync_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_msync |-> bus_rd);
endmodule

// File: rtl/rd_slave.sv
module rd_slave
    import async_rd_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 16,
    parameter int LAT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAT_W-1:0]  lat_cycles,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_msync_in,
    output logic              bus_ssync,
    output logic [DATA_W-1:0] bus_data
);
    localparam int DEPTH = 1 << ADDR_W;

    slv_state_e        state_q, state_d;
    logic [LAT_W-1:0]  cnt_q;
    logic              msync_s;
    logic [DATA_W-1:0] table_w [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_table
            assign table_w[g] = DATA_W'(word_seed(g));
        end
    endgenerate

    sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_msync_in),
        .q     (msync_s)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (msync_s && bus_rd) state_d = S_LATENCY;
            S_LATENCY: if (cnt_q == '0)       state_d = S_ACK;
            S_ACK:     if (!msync_s)          state_d = S_IDLE;
            default:                          state_d = S_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            bus_ssync <= 1'b0;
            bus_data  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (msync_s && bus_rd) cnt_q <= lat_cycles;
                end
                S_LATENCY: begin
                    if (cnt_q == '0) begin
                        bus_data  <= table_w[bus_addr];
                        bus_ssync <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                S_ACK: begin
                    if (!msync_s) begin
                        bus_ssync <= 1'b0;
                        bus_data  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: acknowledge only answers a live request
    assert_ack_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ssync) |-> msync_s);

    // R6: acknowledge drops only after request seen low
    assert_ack_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ssync) |-> !msync_s);

    // R6: data lines released while acknowledge is low
    assert_data_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ssync |-> (bus_data == '0));

    // R5: data held steady through the acknowledge phase
    assert_data_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ssync && $past(bus_ssync)) |-> $stable(bus_data));
endmodule

// File: rtl/async_rd_link.sv
module async_rd_link #(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 16,
    parameter int LAT_W       = 4,
    parameter int SETTLE_CYC  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_m,
    input  logic              rst_m_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              clk_s,
    input  logic              rst_s_n,
    input  logic [LAT_W-1:0]  lat_cycles,
    output logic              link_msync,
    output logic              link_ssync
);
    logic [ADDR_W-1:0] w_addr;
    logic              w_rd;
    logic              w_msync;
    logic              w_ssync;
    logic [DATA_W-1:0] w_data;

    rd_master #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .SETTLE_CYC  (SETTLE_CYC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_master (
        .clk          (clk_m),
        .rst_n        (rst_m_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .bus_addr     (w_addr),
        .bus_rd       (w_rd),
        .bus_msync    (w_msync),
        .bus_ssync_in (w_ssync),
        .bus_data_in  (w_data)
    );

    rd_slave #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .LAT_W       (LAT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_slave (
        .clk          (clk_s),
        .rst_n        (rst_s_n),
        .lat_cycles   (lat_cycles),
        .bus_addr     (w_addr),
        .bus_rd       (w_rd),
        .bus_msync_in (w_msync),
        .bus_ssync    (w_ssync),
        .bus_data     (w_data)
    );

    assign link_msync = w_msync;
    assign link_ssync = w_ssync;
endmodule

// File: tb/async_rd_link_tb.sv
module async_rd_link_tb;
    localparam int S = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [3:0]  lat = '0;
    logic        req_ready, rsp_valid, link_msync, link_ssync;
    logic [15:0] rsp_data;

    int total = 0;
    int bad = 0;
    int t = -1;
    int cur_lat = 0;
    int cur_addr = 0;
    bit busy_noise = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    async_rd_link u_dut (
        .clk_m      (clk),
        .rst_m_n    (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .clk_s      (clk),
        .rst_s_n    (rst_n),
        .lat_cycles (lat),
        .link_msync (link_msync),
        .link_ssync (link_ssync)
    );

    function automatic logic [15:0] exp_word(input int k);
        return 16'((k * 32'h1357) ^ 32'hA5C3);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle model: counts cycles since acceptance, compared after every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            t = -1;
        end else if (t < 0) begin
            if (req_valid) begin
                t = 0;
                cur_addr = int'(req_addr);
                cur_lat = int'(lat);
            end
        end else begin
            t++;
            if (t == S + cur_lat + 13) t = -1;
        end
        #1;
        if (!done) begin
            if (!rst_n) begin
                chk("R1 ready",  {31'd0, req_ready},  32'd1);
                chk("R1 valid",  {31'd0, rsp_valid},  32'd0);
                chk("R1 msync",  {31'd0, link_msync}, 32'd0);
                chk("R1 ssync",  {31'd0, link_ssync}, 32'd0);
            end else begin
                chk("R7/R8 ready", {31'd0, req_ready}, {31'd0, t < 0});
                chk("R2 msync", {31'd0, link_msync},
                    {31'd0, (t >= S) && (t < S + cur_lat + 7)});
                chk("R3/R6/R9 ssync", {31'd0, link_ssync},
                    {31'd0, (t >= S + cur_lat + 4) && (t < S + cur_lat + 10)});
                chk("R4 pulse", {31'd0, rsp_valid}, {31'd0, t == S + cur_lat + 7});
                if (t == S + cur_lat + 7)
                    chk(busy_noise ? "R5/R8 data" : "R5 data",
                        {16'd0, rsp_data}, {16'd0, exp_word(cur_addr)});
            end
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (t >= 0);
    endtask

    task automatic do_read(input int a, input int l, input bit noise);
        wait_idle();
        lat = 4'(l);
        req_addr = 3'(a);
        req_valid = 1'b1;
        busy_noise = noise;
        @(negedge clk);
        if (noise) begin
            // R8: stray requests while busy
            for (int i = 0; i < S + 8; i++) begin
                req_addr = 3'(a + 3 + i);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int a = 0; a < 8; a++) do_read(a, 0, 1'b0);   // R5 every word
        do_read(5, 5, 1'b0);                                // R9
        do_read(2, 15, 1'b0);                               // R9 max
        do_read(7, 1, 1'b1);                                // R8
        do_read(1, 3, 1'b1);                                // R8
        // R7 back-to-back with request held high
        wait_idle();
        lat = 4'd2;
        req_addr = 3'd6;
        req_valid = 1'b1;
        repeat (3 * (S + 2 + 14)) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        done = 1'b1;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule